// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port sitting behind a simple 32-bit register bus. Each pin has a drive-enable bit and an output level. Drive-enable bits never change through a plain store. Software writes a one to the bits it wants in a set register, or to the bits it wants in a clear register, and all other bits keep their value. Output levels are split across two half-port registers, one for pins 0-15 and one for pins 16-31. Each store to one of these registers carries a per-bit write mask in bits 31:16 and the new levels in bits 15:0. As a result, no pin update ever needs a read-modify-write sequence.

The pad inputs pass through a two-stage synchronizer and can then be read as one 32-bit word. A pin's output level may be loaded while the pin is still an input. When its drive enable is set afterwards, the pin drives that value from the first cycle. The bus has valid, write, address, write-data and read-data signals. Read data is combinational in the same cycle, and writes take effect at the next rising clock edge. Address decode is a small enumerated register select, resolved with a unique case.

Top module: `pio_port`

## Requirements
- R1: An active-low reset clears every drive-enable bit, so all pins start as inputs, and clears all 32 output levels to 0.
- R2: A write to offset 0x00 sets the drive-enable bit of every pin whose write-data bit is 1. Pins written with 0 keep their drive-enable state.
- R3: A write to offset 0x04 clears the drive-enable bit of every pin whose write-data bit is 1. Pins written with 0 keep their drive-enable state.
- R4: A read of offset 0x04 returns the current 32-bit drive-enable mask, with bit n belonging to pin n. A read of offset 0x00 returns zero.
- R5: A write to offset 0x08 updates output bit k (pins 0-15) to write-data bit k only where write-data bit 16+k is 1. Other bits keep their level.
- R6: A write to offset 0x0C applies the same masked rule to pins 16-31, with write-data bit k mapping to pin 16+k.
- R7: A read of offset 0x08 or 0x0C returns that half's 16 current output levels in bits 15:0 and zero in bits 31:16.
- R8: A read of offset 0x10 returns the pad input levels, with bit n belonging to pin n. A change on the pads shows up after exactly two rising clock edges, and not after one.
- R9: Reads of undecoded offsets return zero. Writes to undecoded offsets change no state. The read data is zero whenever no read is in progress.
- R10: Each pad output always carries its output level, whether or not the pin is driven. A level loaded while the drive enable is clear therefore appears on the pin as soon as the drive enable is set.
- R11: A write to the read-only input offset 0x10 changes no drive-enable or output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pad_out | output | 32 | Output level for each pin |
| pad_oe | output | 32 | Drive enable for each pin |
| pad_in | input | 32 | Raw pad input levels |

## Verification
A corrupted drive-enable bit shows on `pad_oe` in the cycle after the faulty write, and on the next read of offset 0x04. A mask decoding error in the half-port logic shows as a changed `pad_out` bit on the edge of the store that should have left it alone. The check right after each store catches that directly. A synchronizer with the wrong depth is caught by reading the input word both one edge and two edges after a pad change.

// File: rtl/pio_pkg.sv
package pio_pkg;
    // Register offsets; software relies on these, so they are fixed.
    localparam int OFS_DIR_SET = 'h00;
    localparam int OFS_DIR_CLR = 'h04;
    localparam int OFS_OUT_LO  = 'h08;
    localparam int OFS_OUT_HI  = 'h0C;
    localparam int OFS_PIN_IN  = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_PIN_IN
    } reg_sel_e;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(OFS_DIR_SET))      sel = SEL_DIR_SET;
        else if (addr == ADDR_W'(OFS_DIR_CLR)) sel = SEL_DIR_CLR;
        else if (addr == ADDR_W'(OFS_OUT_LO))  sel = SEL_OUT_LO;
        else if (addr == ADDR_W'(OFS_OUT_HI))  sel = SEL_OUT_HI;
        else if (addr == ADDR_W'(OFS_PIN_IN))  sel = SEL_PIN_IN;
        else                                   sel = SEL_NONE;
    end
endmodule

// File: rtl/pio_dir_reg.sv
module pio_dir_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] oe_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       oe_q <= '0;
        else if (set_stb) oe_q <= oe_q | bits;
        else if (clr_stb) oe_q <= oe_q & ~bits;
    end
endmodule

// File: rtl/pio_out_half.sv
module pio_out_half #(
    parameter int DATA_W = 32,
    localparam int HALF  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF-1:0]   lvl_q
);
    logic [HALF-1:0] mask;
    logic [HALF-1:0] val;
    assign mask = wdata[DATA_W-1:HALF];
    assign val  = wdata[HALF-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lvl_q <= '0;
        else if (wr_stb) lvl_q <= (lvl_q & ~mask) | (val & mask);
    end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    input  logic [DATA_W-1:0] pad_in
);
    localparam int HALF = DATA_W / 2;

    reg_sel_e          sel;
    logic              wr, rd;
    logic [DATA_W-1:0] in_sync;
    logic [HALF-1:0]   lvl [2];

    assign wr = bus_valid &  bus_write;
    assign rd = bus_valid & ~bus_write;

    pio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pio_dir_reg #(.WIDTH(DATA_W)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr && sel == SEL_DIR_SET),
        .clr_stb (wr && sel == SEL_DIR_CLR),
        .bits    (bus_wdata),
        .oe_q    (pad_oe)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam reg_sel_e MY_SEL = (h == 0) ? SEL_OUT_LO : SEL_OUT_HI;
        pio_out_half #(.DATA_W(DATA_W)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr && sel == MY_SEL),
            .wdata  (bus_wdata),
            .lvl_q  (lvl[h])
        );
        assign pad_out[h*HALF +: HALF] = lvl[h];
    end

    pio_sync #(.WIDTH(DATA_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_DIR_CLR: bus_rdata = pad_oe;
                SEL_OUT_LO:  bus_rdata = {{HALF{1'b0}}, lvl[0]};
                SEL_OUT_HI:  bus_rdata = {{HALF{1'b0}}, lvl[1]};
                SEL_PIN_IN:  bus_rdata = in_sync;
                SEL_DIR_SET,
                SEL_NONE:    bus_rdata = '0;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe
);
    localparam int HALF = DATA_W / 2;

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'('h00))
        |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'('h04))
        |=> ((pad_oe & $past(bus_wdata)) == '0));

    a_r4_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'('h04))
        |-> (bus_rdata == pad_oe));

    a_r5_unmasked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'('h08))
        |=> (((pad_out[HALF-1:0] ^ $past(pad_out[HALF-1:0]))
              & ~$past(bus_wdata[DATA_W-1:HALF])) == '0));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> ($stable(pad_oe) && $stable(pad_out)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |-> (bus_rdata == '0));
endmodule

bind pio_port pio_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/pio_port_test.sv
module pio_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // {is_write, addr, wdata, expected read data}
    localparam logic [72:0] VEC [NVEC] = '{
        {1'b0, 8'h04, 32'h0000_0000, 32'h0000_0000},  // R1 mask clear
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0000},  // R1 levels clear
        {1'b1, 8'h00, 32'h0000_00F0, 32'h0},
        {1'b0, 8'h04, 32'h0, 32'h0000_00F0},          // R2
        {1'b1, 8'h00, 32'h8000_0001, 32'h0},
        {1'b0, 8'h04, 32'h0, 32'h8000_00F1},          // R2
        {1'b1, 8'h04, 32'h0000_0030, 32'h0},
        {1'b0, 8'h04, 32'h0, 32'h8000_00C1},          // R3
        {1'b1, 8'h08, 32'h00FF_ABCD, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_00CD},          // R5 R7
        {1'b1, 8'h08, 32'hFF00_1234, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_12CD},          // R5
        {1'b1, 8'h0C, 32'h0003_FFFF, 32'h0},
        {1'b0, 8'h0C, 32'h0, 32'h0000_0003},          // R6 R7
        {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h04, 32'h0, 32'h8000_00C1},          // R9 write ignored
        {1'b0, 8'h20, 32'h0, 32'h0000_0000},          // R9 undecoded read
        {1'b0, 8'h00, 32'h0, 32'h0000_0000},          // R4 set offset reads 0
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_12CD}           // R11
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pad_out, pad_oe, pad_in = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge; read data is combinational, sampled 1 time unit later.
    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_valid = 0; bus_write = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R1 oe in reset", pad_oe, 32'h0);
        check("R1 out in reset", pad_out, 32'h0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][72], VEC[i][71:64], VEC[i][63:32], rd);
            if (!VEC[i][72]) check($sformatf("vector %0d", i), rd, VEC[i][31:0]);
        end

        // R10: load level for pin 20 while not driven, then enable drive.
        access(1'b1, 8'h0C, 32'h0010_0010, rd);
        @(negedge clk);
        check("R10 level preloaded", 32'(pad_out[20]), 32'h1);
        check("R10 still undriven", 32'(pad_oe[20]), 32'h0);
        access(1'b1, 8'h00, 32'h0010_0000, rd);
        @(negedge clk);
        check("R10 drives preloaded level", {31'b0, pad_oe[20] & pad_out[20]}, 32'h1);
        check("R6 pad_out word", pad_out, 32'h0013_12CD);

        // R9: no read in progress gives zero read data.
        @(negedge clk);
        bus_addr = 8'h04; bus_valid = 0;
        #1 check("R9 idle rdata", bus_rdata, 32'h0);

        // R8: two-edge synchronizer.
        @(negedge clk);
        pad_in = 32'hA5A5_0F0F;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h10;
        #1 check("R8 after one edge", bus_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1 check("R8 after two edges", bus_rdata, 32'hA5A5_0F0F);
        bus_valid = 0;

        // R1: reset mid-run clears everything again.
        @(negedge clk);
        rst_n = 0;
        #1 check("R1 oe after reset", pad_oe, 32'h0);
        check("R1 out after reset", pad_out, 32'h0);
        @(negedge clk);
        rst_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule